// File: doc/BRIEF.md
# Processor-Side Bus Yield Arbiter

This block sits next to a processor's bus cycle sequencer and decides when an alternate bus master may take over the local bus. An external master either asks with a request line and waits for a grant, or takes the bus directly by raising its acknowledge line alone. Once the bus is given up, the block drives an enable that places the processor's bus buffers in high impedance. It keeps that enable active until the acknowledge goes away.

Grants are issued only between bus cycles. They are withheld while a locked read-modify-write sequence is past its first read. A coincident bus error, halt and request forces an immediate relinquish with a retry indication, and this overrides both the cycle boundary and the lock. A separate monitor reports when the address strobe has been idle long enough for an alternate master to drive the bus safely.

Top module: `bus_yield_arbiter`

## Requirements
- R1: While `rst_n` is low, `bus_grant`, `buf_float`, `retry_req` and `bus_free` are all 0. Reset release is synchronized over two clock edges, and the machine then starts idle.
- R2: `bus_req` and `bus_ack` each pass through two synchronizing flops. With no bus cycle active and no lock, `bus_grant` is first high after the fourth rising edge following the rise of `bus_req`.
- R3: `bus_grant` never rises while `cyc_busy` is high, except by R10. A pending request is granted on the first edge at which `cyc_busy` is sampled low.
- R4: When the acknowledge is seen while the grant is out and the request is still high, `bus_grant` drops and `buf_float` is driven to 1, three edges after `bus_ack` rises.
- R5: After the request is removed with the acknowledge still high, `buf_float` stays 1. Removing the acknowledge returns the machine to idle with `buf_float` 0. A request raised again while the acknowledge is held keeps `buf_float` at 1.
- R6: From idle, `bus_ack` alone sets `buf_float` to 1 three edges later without any grant (single-wire takeover).
- R7: While `rmw_lock`=1 and `rmw_first`=0, requests are ignored and no grant is issued. A request still held when the lock clears is granted two edges later.
- R8: While `rmw_lock`=1 and `rmw_first`=1, arbitration behaves as in R2.
- R9: Single-wire takeover (R6) is honoured while `rmw_lock`=1 and `rmw_first`=0.
- R10: `bus_err`, `bus_halt` and the synchronized request all high in the same cycle, while idle or waiting and without an acknowledge, raise `retry_req` for exactly one cycle and `bus_grant` on the next edge, regardless of `cyc_busy` and the lock. Without a request, no retry occurs.
- R11: `bus_free` (active high) is 1 only after `strobe_n` has been sampled high on two consecutive edges. It returns to 0 on the edge at which `strobe_n` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Bus request from the alternate master (asynchronous) |
| bus_ack | input | 1 | Grant acknowledge / takeover from the alternate master (asynchronous) |
| cyc_busy | input | 1 | A processor bus cycle is in progress |
| strobe_n | input | 1 | Address strobe, active low |
| rmw_lock | input | 1 | Read-modify-write sequence in progress |
| rmw_first | input | 1 | Current cycle is the first read of the read-modify-write sequence |
| bus_err | input | 1 | Bus error |
| bus_halt | input | 1 | Halt |
| bus_grant | output | 1 | Bus grant to the alternate master |
| buf_float | output | 1 | Places the processor bus buffers in high impedance |
| retry_req | output | 1 | One-cycle pulse: relinquish now and repeat the interrupted cycle |
| bus_free | output | 1 | Strobe idle on two consecutive edges |

## Verification
Two functions can fall in the same cycle: the lock's suppression of grants and the relinquish-and-retry override. The bench holds a request that the lock is blocking during an active bus cycle. It then raises bus error and halt together in one cycle and expects `retry_req` and `bus_grant` to appear together on the very next edge, with the retry gone one edge later. A second collision pairs the lock with a bare acknowledge, which must still float the buffers.

// File: rtl/yield_arb_pkg.sv
package yield_arb_pkg;

  localparam int ST_COUNT = 5;

  typedef enum logic [ST_COUNT-1:0] {
    ST_IDLE  = 5'b00001,
    ST_WAIT  = 5'b00010,
    ST_GRANT = 5'b00100,
    ST_HELD  = 5'b01000,
    ST_REL   = 5'b10000
  } arb_state_e;

endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/strobe_idle_mon.sv
module strobe_idle_mon #(
  parameter int IDLE_EDGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic free_o
);

  localparam int CW = $clog2(IDLE_EDGES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_EDGES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Count only while below the limit, or to clear on a low strobe.
  assign cnt_en = !strobe_ni || (cnt_q != LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (!strobe_ni) cnt_d = '0;
    else            cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign free_o = (cnt_q == LIMIT);

  // R11: free only follows a high strobe on the edge just gone
  p_free_after_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |-> $past(strobe_ni));

  // R11: a low strobe always clears the free flag
  p_free_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_ni |=> !free_o);

endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
  import yield_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  input  logic cyc_busy_i,
  input  logic rmw_lock_i,
  input  logic rmw_first_i,
  input  logic berr_i,
  input  logic halt_i,
  output logic grant_o,
  output logic float_o,
  output logic retry_o
);

  arb_state_e state_q, state_d;
  logic       retry_q, retry_d;
  logic       lock_block;
  logic       retry_hit;
  logic       pre_grant;

  assign lock_block = rmw_lock_i && !rmw_first_i;
  assign pre_grant  = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign retry_hit  = pre_grant && berr_i && halt_i && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ack_i)                    state_d = req_i ? ST_HELD : ST_REL;
        else if (retry_hit)           state_d = ST_GRANT;
        else if (req_i && !lock_block) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (ack_i)                    state_d = req_i ? ST_HELD : ST_REL;
        else if (retry_hit)           state_d = ST_GRANT;
        else if (!req_i)              state_d = ST_IDLE;
        else if (!cyc_busy_i && !lock_block) state_d = ST_GRANT;
      end
      ST_GRANT: begin
        if (ack_i)                    state_d = req_i ? ST_HELD : ST_REL;
        else if (!req_i)              state_d = ST_IDLE;
      end
      ST_HELD: begin
        if (!ack_i)                   state_d = req_i ? ST_WAIT : ST_IDLE;
        else if (!req_i)              state_d = ST_REL;
      end
      ST_REL: begin
        if (!ack_i)                   state_d = ST_IDLE;
        else if (req_i)               state_d = ST_HELD;
      end
      default:                        state_d = ST_IDLE;
    endcase
  end

  assign retry_d = retry_hit && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      retry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      retry_q <= retry_d;
    end
  end

  assign grant_o = (state_q == ST_GRANT);
  assign float_o = (state_q == ST_HELD) || (state_q == ST_REL);
  assign retry_o = retry_q;

  // R1: state register stays one-hot
  p_state_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));

  // R3: grant rises only at a cycle boundary or by retry override
  p_grant_at_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> ($past(!cyc_busy_i) || retry_o));

  // R7: no grant out of a locked read-modify-write except by retry
  p_no_grant_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> ($past(!(rmw_lock_i && !rmw_first_i)) || retry_o));

  // R6: a bare acknowledge from idle floats the buffers next edge
  p_single_wire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && ack_i) |=> float_o);

  // R5: losing the acknowledge while released ends floating
  p_release_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL && !ack_i) |=> !float_o);

  // R10: retry is a single-cycle pulse accompanied by the grant
  p_retry_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);
  p_retry_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> grant_o);

endmodule

// File: rtl/bus_yield_arbiter.sv
module bus_yield_arbiter #(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic bus_ack,
  input  logic cyc_busy,
  input  logic strobe_n,
  input  logic rmw_lock,
  input  logic rmw_first,
  input  logic bus_err,
  input  logic bus_halt,
  output logic bus_grant,
  output logic buf_float,
  output logic retry_req,
  output logic bus_free
);

  localparam int NSYNC = 2;

  logic             rst_int_n;
  logic [NSYNC-1:0] raw_in, synced;
  logic             req_s, ack_s;

  // Reset: asserts at once, releases after SYNC_STAGES edges.
  sync_stage #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .d_i    (1'b1),
    .q_o    (rst_int_n)
  );

  assign raw_in = {bus_ack, bus_req};

  sync_stage #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i  (clk),
    .rst_ni (rst_int_n),
    .d_i    (raw_in),
    .q_o    (synced)
  );

  assign req_s = synced[0];
  assign ack_s = synced[1];

  yield_fsm u_fsm (
    .clk_i       (clk),
    .rst_ni      (rst_int_n),
    .req_i       (req_s),
    .ack_i       (ack_s),
    .cyc_busy_i  (cyc_busy),
    .rmw_lock_i  (rmw_lock),
    .rmw_first_i (rmw_first),
    .berr_i      (bus_err),
    .halt_i      (bus_halt),
    .grant_o     (bus_grant),
    .float_o     (buf_float),
    .retry_o     (retry_req)
  );

  strobe_idle_mon #(.IDLE_EDGES(IDLE_EDGES)) u_mon (
    .clk_i     (clk),
    .rst_ni    (rst_int_n),
    .strobe_ni (strobe_n),
    .free_o    (bus_free)
  );

  // R4: grant and buffer float are never active together
  p_grant_float_excl_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(bus_grant && buf_float));

endmodule

// File: tb/tb_bus_yield_arbiter.sv
`timescale 1ns/1ps
module tb_bus_yield_arbiter;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_req, bus_ack, cyc_busy, strobe_n, rmw_lock, rmw_first, bus_err, bus_halt;
  logic bus_grant, buf_float, retry_req, bus_free;

  always #2.5 clk = ~clk;

  bus_yield_arbiter dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
    .cyc_busy(cyc_busy), .strobe_n(strobe_n), .rmw_lock(rmw_lock),
    .rmw_first(rmw_first), .bus_err(bus_err), .bus_halt(bus_halt),
    .bus_grant(bus_grant), .buf_float(buf_float), .retry_req(retry_req),
    .bus_free(bus_free)
  );

  typedef struct {
    int    due;
    logic  g, t, r, f;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops due expectations half a phase after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if ({bus_grant, buf_float, retry_req, bus_free} !== {e.g, e.t, e.r, e.f}) begin
          bad++;
          $display("FAIL %s: got grant/float/retry/free=%b%b%b%b expected %b%b%b%b",
                   e.tag, bus_grant, buf_float, retry_req, bus_free, e.g, e.t, e.r, e.f);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic g, input logic t, input logic r,
                            input logic f, input string tag);
    exp_t e;
    e.due = cyc; e.g = g; e.t = t; e.r = r; e.f = f; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 0; bus_ack = 0; cyc_busy = 0; strobe_n = 1;
    rmw_lock = 0; rmw_first = 0; bus_err = 0; bus_halt = 0;

    step(3);
    expect_out(0, 0, 0, 0, "R1 outputs in reset");
    rst_n = 1'b1;
    step(3);
    expect_out(0, 0, 0, 0, "R11 free not yet after one idle edge");
    step(1);
    expect_out(0, 0, 0, 1, "R11 free after two idle edges / R1 idle");

    // R2: request latency through the synchronizer
    bus_req = 1;
    step(3);
    expect_out(0, 0, 0, 1, "R2 no grant before fourth edge");
    step(1);
    expect_out(1, 0, 0, 1, "R2 grant on fourth edge");
    // R4: acknowledge with request held
    bus_ack = 1;
    step(3);
    expect_out(0, 1, 0, 1, "R4 float and grant dropped");
    // R5: request removed, float kept
    bus_req = 0;
    step(3);
    expect_out(0, 1, 0, 1, "R5 float held after request removed");
    bus_ack = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R5 idle after acknowledge removed");

    // R3: grant waits for the bus cycle to end
    cyc_busy = 1; bus_req = 1;
    step(6);
    expect_out(0, 0, 0, 1, "R3 no grant during bus cycle");
    cyc_busy = 0;
    step(1);
    expect_out(1, 0, 0, 1, "R3 grant at cycle end");
    bus_req = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R3 grant withdrawn with request");

    // R6: single-wire takeover, then re-request while released
    bus_ack = 1;
    step(3);
    expect_out(0, 1, 0, 1, "R6 bare acknowledge floats bus");
    bus_req = 1;
    step(3);
    expect_out(0, 1, 0, 1, "R5 new request keeps float");
    bus_req = 0; bus_ack = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R5 return to idle");

    // R7: locked sequence blocks grants
    rmw_lock = 1; rmw_first = 0; bus_req = 1;
    step(8);
    expect_out(0, 0, 0, 1, "R7 request ignored under lock");
    rmw_lock = 0;
    step(2);
    expect_out(1, 0, 0, 1, "R7 held request granted after unlock");
    bus_req = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R7 idle again");

    // R8: first read of the sequence arbitrates normally
    rmw_lock = 1; rmw_first = 1; bus_req = 1;
    step(4);
    expect_out(1, 0, 0, 1, "R8 grant during first read");
    bus_req = 0; rmw_lock = 0; rmw_first = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R8 idle again");

    // R9: single-wire under lock
    rmw_lock = 1;
    bus_ack = 1;
    step(3);
    expect_out(0, 1, 0, 1, "R9 takeover honoured under lock");
    bus_ack = 0; rmw_lock = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R9 idle again");

    // R10: retry overrides lock and busy cycle
    rmw_lock = 1; cyc_busy = 1; bus_req = 1;
    step(4);
    expect_out(0, 0, 0, 1, "R10 request blocked before retry");
    bus_err = 1; bus_halt = 1;
    step(1);
    expect_out(1, 0, 1, 1, "R10 retry and grant together");
    bus_err = 0; bus_halt = 0;
    step(1);
    expect_out(1, 0, 0, 1, "R10 retry lasts one cycle");
    bus_req = 0; rmw_lock = 0; cyc_busy = 0;
    step(3);
    expect_out(0, 0, 0, 1, "R10 idle after request drops");
    bus_err = 1; bus_halt = 1;
    step(1);
    expect_out(0, 0, 0, 1, "R10 no retry without request");
    bus_err = 0; bus_halt = 0;

    // R11: strobe activity clears and re-arms the monitor
    strobe_n = 0;
    step(1);
    expect_out(0, 0, 0, 0, "R11 free cleared by low strobe");
    strobe_n = 1;
    step(1);
    expect_out(0, 0, 0, 0, "R11 one idle edge not enough");
    step(1);
    expect_out(0, 0, 0, 1, "R11 free after two idle edges");

    step(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hung expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule